// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits behind the write port of a parallel NOR flash model and interprets the classic multi-cycle command protocol. Each bus write carries a byte address and a data word. The block reduces the address to a word offset inside the current sector, then steps through the unlock cycles and latches the command that follows. It issues program and erase work to a storage back end. It also tells the read path which view to return: array data, identification, the query table, or status.

Programming clears bits only, so the back end stores the old word AND the new one. Erasing is done as a run of all-ones word writes over one sector or over the whole chip. An unlock-bypass shortcut lets software program with two writes per word instead of four. Read-only builds keep the exact state sequencing but never touch the array. The chip size, sector size, bus width and the two unlock offsets are parameters.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `rd_mode` is 0 (array view), `be_valid` is low and unlock bypass is off.
- R2: An address is first cut to the chip size. It is then reduced to its word offset inside its sector: the byte offset is shifted right by log2 of the bus width in bytes. Only that offset is compared with the unlock and query offsets, so any sector and any alias above the chip size unlock the same way.
- R3: In the idle state, data 0x98 at word offset 0x55 gives `rd_mode` 2 (query view) at once. Any idle write other than 0x98 at 0x55 or 0xAA at unlock offset 0 leaves `rd_mode` at 0.
- R4: 0xAA at unlock offset 0, then 0x55 at unlock offset 1, then 0x90 at unlock offset 0 gives `rd_mode` 1 (identification view). A wrong second cycle returns to idle, so a following 0x90 has no effect.
- R5: 0xAA/0x55/0xA0 gives `rd_mode` 3 (status). The next write issues one back-end request with `be_op` 0 (program: the stored word becomes old AND data), `be_addr` equal to the chip-masked byte address shifted right by log2 of the bus width, and `be_data` equal to the write data. After it is accepted, `rd_mode` returns to 0.
- R6: A write of data 0xF0 returns to idle and clears bypass from every state except the program data cycle. In that cycle 0xF0 is programmed like any other data.
- R7: Command 0x20 in the third cycle enables bypass. With bypass on, the command cycle accepts any address, 0xA0 followed by one data write programs a word, and the sequencer then returns to the command cycle instead of idle.
- R8: In the identification view, data 0x00 with bypass on leaves bypass and returns to idle. Data 0x98 at word offset 0x55 enters the query view. Any other write returns to idle.
- R9: After 0x80, a second 0xAA/0x55 pair, then 0x10 at unlock offset 0, the block issues fill requests (`be_op` 1, data all ones) for every word of the chip, in ascending order from word 0. 0x10 at any other offset returns to idle with no request.
- R10: In the same sequence, 0x30 at any address issues fill requests for every word of the sector that contains that address, ascending from the sector's first word.
- R11: While a program or erase is being carried out, writes are ignored and `rd_mode` stays 3. In the query view, any write returns to `rd_mode` 0.
- R12: While `be_valid` is high and `be_ready` is low, `be_valid`, `be_op`, `be_addr` and `be_data` hold steady.
- R13: With `READ_ONLY` set, no request is ever issued. The same writes still move through the same states, and a program or erase shows status for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One bus write in this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8*BUS_BYTES | Write data; command byte in bits 7:0 |
| rd_mode | output | 2 | Read view: 0 array, 1 identification, 2 query, 3 status |
| be_valid | output | 1 | Back-end request valid |
| be_ready | input | 1 | Back end accepts the request |
| be_op | output | 1 | 0 program (AND into word), 1 fill with all ones |
| be_addr | output | WORD_AW | Word address of the request |
| be_data | output | 8*BUS_BYTES | Data of the request |

## Verification
The hardest situations to reach are those that sit deep in the command sequence: 0xF0 arriving as program data, a write landing in the middle of a sector fill, and the exit from bypass through the identification view. The stimulus builds each one with full unlock sequences, and it checks that bypass was really cleared by sending a bypass-only command and seeing no effect. Back-pressure is made both by a periodic stall pattern during the chip fill and by holding ready low across a program, with a reset write sent while the program is stalled. A second, read-only instance sees the same writes, so its one-cycle status windows and its silent back-end port are compared against the writable one.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_QUERY  = 2'd2,
        MODE_STATUS = 2'd3
    } rd_mode_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_FILL    = 1'b1
    } be_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNLOCK_B,
        ST_COMMAND,
        ST_PROG_DATA,
        ST_PROG_BUSY,
        ST_ERASE_A,
        ST_ERASE_B,
        ST_ERASE_CMD,
        ST_ERASING,
        ST_IDENT,
        ST_QUERY
    } seq_state_e;

    localparam logic [7:0] CMD_KEY_A    = 8'hAA;
    localparam logic [7:0] CMD_KEY_B    = 8'h55;
    localparam logic [7:0] CMD_BYPASS   = 8'h20;
    localparam logic [7:0] CMD_ERASE_SU = 8'h80;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_QUERY    = 8'h98;
    localparam logic [7:0] CMD_RESET    = 8'hF0;
    localparam logic [7:0] CMD_CHIP_ER  = 8'h10;
    localparam logic [7:0] CMD_SECT_ER  = 8'h30;
    localparam logic [7:0] CMD_BYP_EXIT = 8'h00;
    localparam int         QUERY_OFFSET = 'h55;

endpackage

// File: rtl/nor_addr_decode.sv
module nor_addr_decode #(
    parameter int ADDR_W       = 24,
    parameter int CHIP_BYTES   = 16384,
    parameter int SECTOR_BYTES = 4096,
    parameter int BUS_BYTES    = 2,
    localparam int CHIP_AW     = $clog2(CHIP_BYTES),
    localparam int SECT_AW     = $clog2(SECTOR_BYTES),
    localparam int SHIFT       = $clog2(BUS_BYTES),
    localparam int WORD_AW     = CHIP_AW - SHIFT,
    localparam int SOFF_W      = SECT_AW - SHIFT
) (
    input  logic [ADDR_W-1:0]  byte_addr,
    output logic [SOFF_W-1:0]  sect_off,
    output logic [WORD_AW-1:0] word_addr,
    output logic [WORD_AW-1:0] sect_base
);

    logic [CHIP_AW-1:0] chip_off;
    logic               unused_high;

    // Address aliases beyond the chip fold onto it.
    assign chip_off    = byte_addr[CHIP_AW-1:0];
    assign unused_high = ^byte_addr[ADDR_W-1:CHIP_AW];

    assign word_addr = chip_off[CHIP_AW-1:SHIFT];
    assign sect_off  = chip_off[SECT_AW-1:SHIFT];
    assign sect_base = {chip_off[CHIP_AW-1:SECT_AW], {SOFF_W{1'b0}}};

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_seq_pkg::*;
#(
    parameter int SOFF_W  = 11,
    parameter int UNLOCK0 = 'h555,
    parameter int UNLOCK1 = 'h2AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [7:0]        cmd,
    input  logic [SOFF_W-1:0] sect_off,
    input  logic              job_done,
    output rd_mode_e          mode,
    output logic              start_prog,
    output logic              start_erase,
    output logic              erase_whole
);

    typedef struct packed {
        seq_state_e st;
        logic       bypass;
    } fsm_t;

    fsm_t d, q;
    logic hit_u0, hit_u1, hit_qry, is_busy;

    assign hit_u0  = (sect_off == SOFF_W'(UNLOCK0));
    assign hit_u1  = (sect_off == SOFF_W'(UNLOCK1));
    assign hit_qry = (sect_off == SOFF_W'(QUERY_OFFSET));
    assign is_busy = (q.st == ST_PROG_BUSY) || (q.st == ST_ERASING);

    always_comb begin
        d           = q;
        start_prog  = 1'b0;
        start_erase = 1'b0;
        erase_whole = 1'b0;
        if (is_busy) begin
            if (job_done) begin
                d.st = q.bypass ? ST_COMMAND : ST_IDLE;
            end
        end else if (wr_valid) begin
            if (cmd == CMD_RESET && q.st != ST_PROG_DATA) begin
                d.st     = ST_IDLE;
                d.bypass = 1'b0;
            end else begin
                d.st     = ST_IDLE;
                d.bypass = 1'b0;
                case (q.st)
                    ST_IDLE, ST_ERASE_A: begin
                        d.bypass = q.bypass;
                        if (hit_qry && cmd == CMD_QUERY) begin
                            d.st = ST_QUERY;
                        end else if (hit_u0 && cmd == CMD_KEY_A) begin
                            d.st = (q.st == ST_IDLE) ? ST_UNLOCK_B : ST_ERASE_B;
                        end else begin
                            d.bypass = 1'b0;
                        end
                    end
                    ST_UNLOCK_B: begin
                        if (hit_u1 && cmd == CMD_KEY_B) d.st = ST_COMMAND;
                    end
                    ST_COMMAND: begin
                        if (q.bypass || hit_u0) begin
                            d.bypass = q.bypass;
                            case (cmd)
                                CMD_BYPASS: begin
                                    d.st     = ST_COMMAND;
                                    d.bypass = 1'b1;
                                end
                                CMD_ERASE_SU: d.st = ST_ERASE_A;
                                CMD_IDENT:    d.st = ST_IDENT;
                                CMD_PROGRAM:  d.st = ST_PROG_DATA;
                                default:      d.bypass = 1'b0;
                            endcase
                        end
                    end
                    ST_PROG_DATA: begin
                        d.st       = ST_PROG_BUSY;
                        d.bypass   = q.bypass;
                        start_prog = 1'b1;
                    end
                    ST_ERASE_B: begin
                        if (hit_u1 && cmd == CMD_KEY_B) begin
                            d.st     = ST_ERASE_CMD;
                            d.bypass = q.bypass;
                        end
                    end
                    ST_ERASE_CMD: begin
                        if ((cmd == CMD_CHIP_ER && hit_u0) || cmd == CMD_SECT_ER) begin
                            d.st        = ST_ERASING;
                            d.bypass    = q.bypass;
                            start_erase = 1'b1;
                            erase_whole = (cmd == CMD_CHIP_ER);
                        end
                    end
                    ST_IDENT: begin
                        if (!(q.bypass && cmd == CMD_BYP_EXIT) && hit_qry && cmd == CMD_QUERY) begin
                            d.st = ST_QUERY;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.bypass <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.st)
            ST_IDENT:                            mode = MODE_IDENT;
            ST_QUERY:                            mode = MODE_QUERY;
            ST_PROG_DATA, ST_PROG_BUSY, ST_ERASING: mode = MODE_STATUS;
            default:                             mode = MODE_ARRAY;
        endcase
    end

    // R6: reset command honoured everywhere but the program data cycle
    a_r6_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && cmd == CMD_RESET && !is_busy && q.st != ST_PROG_DATA)
        |=> (mode == MODE_ARRAY && !q.bypass));

    // R11: any write in the query view leaves it
    a_r11_query_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_QUERY && wr_valid) |=> (q.st == ST_IDLE));

    // R11: an erase only ends when the back end reports completion
    a_r11_erase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ERASING && !job_done) |=> (q.st == ST_ERASING));

    // R7: bypass only comes on after a bypass command write
    a_r7_bypass_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.bypass) |-> ($past(wr_valid) && $past(cmd) == CMD_BYPASS));

endmodule

// File: rtl/nor_req_gen.sv
module nor_req_gen
    import nor_seq_pkg::*;
#(
    parameter int WORD_AW    = 13,
    parameter int DATA_W     = 16,
    parameter int SECT_WORDS = 2048,
    parameter int READ_ONLY  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_prog,
    input  logic               start_erase,
    input  logic               erase_whole,
    input  logic [WORD_AW-1:0] word_addr,
    input  logic [WORD_AW-1:0] sect_base,
    input  logic [DATA_W-1:0]  prog_data,
    output logic               job_done,
    output logic               be_valid,
    input  logic               be_ready,
    output be_op_e             be_op,
    output logic [WORD_AW-1:0] be_addr,
    output logic [DATA_W-1:0]  be_data
);

    typedef struct packed {
        logic               busy;
        be_op_e             op;
        logic [WORD_AW-1:0] addr;
        logic [WORD_AW-1:0] last;
        logic [DATA_W-1:0]  data;
    } req_t;

    req_t d, q;
    logic accept, finish;

    generate
        if (READ_ONLY != 0) begin : g_ro
            // Array untouched: the job is declared finished one cycle later.
            assign be_valid = 1'b0;
            assign accept   = 1'b0;
            assign finish   = q.busy;
        end else begin : g_rw
            assign be_valid = q.busy;
            assign accept   = q.busy && be_ready;
            assign finish   = accept && (q.op == OP_PROGRAM || q.addr == q.last);
        end
    endgenerate

    always_comb begin
        d        = q;
        job_done = 1'b0;
        if (q.busy) begin
            if (finish) begin
                d.busy   = 1'b0;
                job_done = 1'b1;
            end else if (accept) begin
                d.addr = q.addr + 1'b1;
            end
        end else if (start_prog) begin
            d.busy = 1'b1;
            d.op   = OP_PROGRAM;
            d.addr = word_addr;
            d.last = word_addr;
            d.data = prog_data;
        end else if (start_erase) begin
            d.busy = 1'b1;
            d.op   = OP_FILL;
            d.addr = erase_whole ? '0 : sect_base;
            d.last = erase_whole ? '1 : (sect_base | WORD_AW'(SECT_WORDS - 1));
            d.data = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign be_op   = q.op;
    assign be_addr = q.addr;
    assign be_data = q.data;

    // R12: a stalled request holds all its fields
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (be_valid && !be_ready) |=> (be_valid && $stable(be_addr) && $stable(be_data) && $stable(be_op)));

    // R9 / R10: fill walks upward one word per accepted request
    a_r10_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        (be_valid && be_ready && be_op == OP_FILL && !job_done)
        |=> (be_valid && be_addr == $past(be_addr) + 1'b1));

    // R13: read-only jobs last a single cycle
    a_r13_ro_quick: assert property (@(posedge clk) disable iff (!rst_n || READ_ONLY == 0)
        q.busy |=> !q.busy);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int CHIP_BYTES   = 16384,
    parameter int SECTOR_BYTES = 4096,
    parameter int BUS_BYTES    = 2,
    parameter int UNLOCK0      = 'h555,
    parameter int UNLOCK1      = 'h2AA,
    parameter int READ_ONLY    = 0,
    localparam int DATA_W      = 8 * BUS_BYTES,
    localparam int WORD_AW     = $clog2(CHIP_BYTES) - $clog2(BUS_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [1:0]         rd_mode,
    output logic               be_valid,
    input  logic               be_ready,
    output logic               be_op,
    output logic [WORD_AW-1:0] be_addr,
    output logic [DATA_W-1:0]  be_data
);

    localparam int SOFF_W     = $clog2(SECTOR_BYTES) - $clog2(BUS_BYTES);
    localparam int SECT_WORDS = SECTOR_BYTES / BUS_BYTES;

    logic [SOFF_W-1:0]  sect_off;
    logic [WORD_AW-1:0] word_addr, sect_base;
    logic               start_prog, start_erase, erase_whole, job_done;
    rd_mode_e           mode;
    be_op_e             op;

    nor_addr_decode #(
        .ADDR_W(ADDR_W), .CHIP_BYTES(CHIP_BYTES),
        .SECTOR_BYTES(SECTOR_BYTES), .BUS_BYTES(BUS_BYTES)
    ) u_dec (
        .byte_addr(wr_addr), .sect_off(sect_off),
        .word_addr(word_addr), .sect_base(sect_base)
    );

    nor_cmd_fsm #(
        .SOFF_W(SOFF_W), .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .cmd(wr_data[7:0]),
        .sect_off(sect_off), .job_done(job_done), .mode(mode),
        .start_prog(start_prog), .start_erase(start_erase), .erase_whole(erase_whole)
    );

    nor_req_gen #(
        .WORD_AW(WORD_AW), .DATA_W(DATA_W),
        .SECT_WORDS(SECT_WORDS), .READ_ONLY(READ_ONLY)
    ) u_req (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
        .erase_whole(erase_whole), .word_addr(word_addr), .sect_base(sect_base),
        .prog_data(wr_data), .job_done(job_done), .be_valid(be_valid),
        .be_ready(be_ready), .be_op(op), .be_addr(be_addr), .be_data(be_data)
    );

    assign rd_mode = mode;
    assign be_op   = op;

    // R5: a pending back-end request always shows the status view
    a_r5_status_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |-> (rd_mode == 2'd3));

    // R1: nothing is requested in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !be_valid);

endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;

    localparam int ADDR_W = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_mode, ro_mode;
    logic        be_valid, be_ready, be_op;
    logic [12:0] be_addr;
    logic [15:0] be_data;
    logic        ro_valid, ro_op;
    logic [12:0] ro_addr;
    logic [15:0] ro_data;

    always #2 clk = ~clk;

    nor_cmd_seq #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_mode(rd_mode), .be_valid(be_valid), .be_ready(be_ready), .be_op(be_op),
        .be_addr(be_addr), .be_data(be_data)
    );

    nor_cmd_seq #(.ADDR_W(ADDR_W), .READ_ONLY(1)) u_dut_ro (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_mode(ro_mode), .be_valid(ro_valid), .be_ready(1'b1), .be_op(ro_op),
        .be_addr(ro_addr), .be_data(ro_data)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Back-end ready pattern
    bit stall_en = 0;
    bit hold_low = 0;
    int cyc = 0;
    initial be_ready = 1'b1;
    always @(posedge clk) begin
        cyc++;
        #1;
        if (hold_low)      be_ready = 1'b0;
        else if (stall_en) be_ready = (cyc % 3) != 0;
        else               be_ready = 1'b1;
    end

    // Scoreboard
    typedef struct {
        bit          fill;
        int unsigned addr;
        int unsigned data;
        int unsigned count;
        string       req;
    } exp_t;
    exp_t q_exp[$];

    task automatic expect_prog(input int unsigned a, input int unsigned dt, input string req);
        q_exp.push_back('{fill: 1'b0, addr: a, data: dt, count: 1, req: req});
    endtask

    task automatic expect_fill(input int unsigned a, input int unsigned n, input string req);
        q_exp.push_back('{fill: 1'b1, addr: a, data: 'hFFFF, count: n, req: req});
    endtask

    exp_t        cur;
    bit          active = 0;
    int unsigned seen   = 0;
    bit          bad    = 0;
    bit          hold_prev = 0;
    logic [12:0] hold_addr;
    logic [15:0] hold_data;
    logic        hold_op;
    bit          ro_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ro_valid) ro_seen = 1;
            if (hold_prev)
                check(be_valid && be_addr == hold_addr && be_data == hold_data && be_op == hold_op,
                      "R12", "stalled request changed", {be_valid, be_addr}, {1'b1, hold_addr});
            hold_prev = be_valid && !be_ready;
            hold_addr = be_addr;
            hold_data = be_data;
            hold_op   = be_op;
            if (be_valid && be_ready) begin
                if (!active) begin
                    if (q_exp.size() == 0) begin
                        check(0, "R9", "unexpected request addr", be_addr, 0);
                    end else begin
                        cur    = q_exp.pop_front();
                        active = 1;
                        seen   = 0;
                        bad    = 0;
                    end
                end
                if (active) begin
                    if (!cur.fill) begin
                        check(be_op == 1'b0 && be_addr == cur.addr[12:0] && be_data == cur.data[15:0],
                              cur.req, "program request {op,addr,data}",
                              {be_op, be_addr, be_data}, {1'b0, cur.addr[12:0], cur.data[15:0]});
                        active = 0;
                    end else begin
                        if (be_op != 1'b1 || be_addr != 13'(cur.addr + seen) || be_data != 16'hFFFF)
                            bad = 1;
                        seen++;
                        if (seen == cur.count) begin
                            check(!bad, cur.req, "fill sequence mismatch", bad, 0);
                            active = 0;
                        end
                    end
                end
            end
        end
    end

    task automatic bw(input logic [23:0] a, input logic [15:0] dt);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = dt;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic unlock();
        bw(24'h000AAA, 16'h00AA);
        bw(24'h000554, 16'h0055);
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while ((rd_mode == 2'd3 || be_valid) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(n < 20000, req, "job did not finish", n, 0);
    endtask

    task automatic chk_mode(input logic [1:0] exp, input string req, input string what);
        check(rd_mode == exp, req, what, rd_mode, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "WD", "watchdog expired", cyc, 150000);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_mode(2'd0, "R1", "mode after reset");
        check(!be_valid, "R1", "valid after reset", be_valid, 0);

        // R3: direct query entry, R11: any write leaves it
        bw(24'h0000AA, 16'h0098);
        chk_mode(2'd2, "R3", "query entry");
        bw(24'h000000, 16'h0012);
        chk_mode(2'd0, "R11", "query exit");
        bw(24'h000100, 16'h0077);
        chk_mode(2'd0, "R3", "stray idle write");

        // R4: identification
        unlock();
        bw(24'h000AAA, 16'h0090);
        chk_mode(2'd1, "R4", "ident entry");
        bw(24'h000000, 16'h0033);
        chk_mode(2'd0, "R8", "ident other write");
        bw(24'h000AAA, 16'h00AA);
        bw(24'h000556, 16'h0055);
        bw(24'h000AAA, 16'h0090);
        chk_mode(2'd0, "R4", "bad second cycle");

        // R2: other sector and chip alias
        bw(24'h001AAA, 16'h00AA);
        bw(24'h004554, 16'h0055);
        bw(24'h003AAA, 16'h0090);
        chk_mode(2'd1, "R2", "aliased unlock");
        bw(24'h000000, 16'h00F0);
        chk_mode(2'd0, "R6", "reset from ident");

        // R5: program
        unlock();
        bw(24'h000AAA, 16'h00A0);
        chk_mode(2'd3, "R5", "status in data wait");
        expect_prog('h123, 'h1234, "R5");
        bw(24'h000246, 16'h1234);
        check(ro_mode == 2'd3, "R13", "ro status window", ro_mode, 3);
        @(negedge clk);
        check(ro_mode == 2'd0, "R13", "ro status one cycle", ro_mode, 0);
        wait_idle("R5");
        chk_mode(2'd0, "R5", "after program");

        // R6: 0xF0 as program data, and as reset mid-unlock
        unlock();
        bw(24'h000AAA, 16'h00A0);
        expect_prog('h008, 'h00F0, "R6");
        bw(24'h000010, 16'h00F0);
        chk_mode(2'd3, "R6", "F0 programmed not reset");
        wait_idle("R6");
        bw(24'h000AAA, 16'h00AA);
        bw(24'h000000, 16'h00F0);
        bw(24'h000554, 16'h0055);
        bw(24'h000AAA, 16'h0090);
        chk_mode(2'd0, "R6", "reset mid unlock");

        // R7: bypass programming
        unlock();
        bw(24'h000AAA, 16'h0020);
        chk_mode(2'd0, "R7", "bypass entry");
        bw(24'h000000, 16'h00A0);
        chk_mode(2'd3, "R7", "bypass program cmd");
        expect_prog('h200, 'hBEEF, "R7");
        bw(24'h000400, 16'hBEEF);
        wait_idle("R7");
        bw(24'h001234, 16'h00A0);
        chk_mode(2'd3, "R7", "bypass still active");
        expect_prog('h1FFF, 'h0F0F, "R7");
        bw(24'h003FFE, 16'h0F0F);
        wait_idle("R7");

        // R8: exit bypass through ident
        bw(24'h000000, 16'h0090);
        chk_mode(2'd1, "R8", "bypass ident");
        bw(24'h000000, 16'h0000);
        chk_mode(2'd0, "R8", "bypass exit");
        bw(24'h000000, 16'h00A0);
        chk_mode(2'd0, "R8", "bypass cleared");

        // R8: ident to query
        unlock();
        bw(24'h000AAA, 16'h0090);
        bw(24'h0000AA, 16'h0098);
        chk_mode(2'd2, "R8", "ident to query");
        bw(24'h000000, 16'h0000);
        chk_mode(2'd0, "R11", "query exit");

        // R10: sector erase with a write during the fill
        unlock();
        bw(24'h000AAA, 16'h0080);
        unlock();
        expect_fill('h1000, 2048, "R10");
        bw(24'h002345, 16'h0030);
        chk_mode(2'd3, "R10", "erase status");
        bw(24'h000000, 16'h00F0);
        chk_mode(2'd3, "R11", "write ignored during erase");
        wait_idle("R10");
        chk_mode(2'd0, "R10", "after sector erase");

        // R9: chip erase under stalls
        stall_en = 1;
        unlock();
        bw(24'h000AAA, 16'h0080);
        unlock();
        expect_fill('h0, 8192, "R9");
        bw(24'h000AAA, 16'h0010);
        wait_idle("R9");
        stall_en = 0;
        unlock();
        bw(24'h000AAA, 16'h0080);
        unlock();
        bw(24'h000000, 16'h0010);
        chk_mode(2'd0, "R9", "chip erase wrong offset");
        repeat (3) @(negedge clk);
        check(!be_valid, "R9", "no request on wrong offset", be_valid, 0);

        // R12 / R11: stalled program with a write during it
        hold_low = 1;
        unlock();
        bw(24'h000AAA, 16'h00A0);
        expect_prog('h001, 'h5555, "R12");
        bw(24'h000002, 16'h5555);
        bw(24'h000000, 16'h00F0);
        chk_mode(2'd3, "R11", "write ignored during program");
        repeat (2) @(negedge clk);
        hold_low = 0;
        wait_idle("R12");

        check(q_exp.size() == 0 && !active, "R5", "expected requests left", q_exp.size(), 0);
        check(!ro_seen, "R13", "read-only issued a request", ro_seen, 0);
        check(ro_mode == 2'd0, "R13", "read-only final mode", ro_mode, 0);
        report();
    end

endmodule